// File: doc/BRIEF.md
# Byte-Serial Status Packet Generator

This block reports a status word of parameterised width to an upstream collector as a short packet on an 8-bit address/data bus. When it has something to report, it raises a request line. It then waits for the collector to acknowledge with a one-cycle start pulse. The first byte is a fixed register address, which appears on the bus in the same cycle as the start pulse. On each following clock the bus carries one packet byte. When the packet is over, the bus returns to zero.

A host control byte arrives with a write strobe. It selects the reporting mode and sets a 6-bit sequence number, which travels in the second byte of every packet. In single-shot mode each control write yields one packet. In automatic mode the control write also yields a packet, and after that any change of the status input yields a further packet. The status word and the sequence number are captured together at the start pulse, so every packet carries one coherent snapshot.

The request/start pair is the block's only flow control. The collector stalls the block simply by withholding start. The block holds its request for as long as that takes. It never sends a byte that was not preceded by an accepted start.

Top module: `status_pkt_gen`

## Requirements
- R1: Synchronous reset sets the mode to disabled and the sequence number to zero, drops `pkt_rq` and drives `pkt_ad` to zero. After reset, status changes raise no request until a control write enables reporting.
- R2: A control write takes `ctl_data[1:0]` as the mode and `ctl_data[7:2]` as the sequence number. The modes are 2'b00 disabled, 2'b01 single-shot and 2'b11 automatic; 2'b10 behaves as disabled.
- R3: A write that selects single-shot or automatic mode raises `pkt_rq` in the cycle after the write. `pkt_rq` then stays high until a cycle in which `pkt_start` is high.
- R4: In a cycle where both `pkt_rq` and `pkt_start` are high, `pkt_ad` equals the parameter `STATUS_ADDR`. A `pkt_start` pulse while `pkt_rq` is low is ignored: the bus stays zero and no packet follows.
- R5: On the clock cycles after the start cycle, the bus carries the following bytes in order. The first is `{seq[5:0], status[1:0]}`, with the sequence number in bits 7:2. Next come `status[9:2]`, `status[17:10]` and `status[25:18]`, as far as the payload width needs. That makes 2+ceil((PAYLOAD_W-2)/8) bytes in all, with the unused high bits of the last byte sent as zero.
- R6: The status word and sequence number are sampled at the clock edge that ends the start cycle. Later changes to either do not alter the bytes of that packet.
- R7: `pkt_ad` is zero whenever no packet byte is being sent, and `pkt_rq` is low while a packet is in progress.
- R8: In automatic mode, a status value that differs from the previous cycle's value raises `pkt_rq` one cycle later. In single-shot mode a status change raises no request.
- R9: In automatic mode, a status change during a packet produces exactly one further request, in the first cycle after that packet's last byte.
- R10: A control write with mode 2'b00 or 2'b10 withdraws a pending request in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_we | input | 1 | Control write strobe |
| ctl_data | input | 8 | Control byte: mode in [1:0], sequence number in [7:2] |
| status_in | input | PAYLOAD_W | Status word to report |
| pkt_ad | output | 8 | Packet address/data bus, zero when idle |
| pkt_rq | output | 1 | Request to send a packet |
| pkt_start | input | 1 | Acknowledge of the first packet byte |

## Verification
The serializer is driven with directed status words and with random ones from a fixed seed. Each byte is compared against a bench model of the packing, so a swapped slice, a wrong shift or a missing zero pad in the last byte shows up in a specific byte position. Directed runs keep `pkt_start` low for several cycles and pulse it while no request is pending, which separates a held request from a re-armed one and an accepted start from a stray one. Changing the status one cycle into a packet checks that the snapshot is taken at the start edge and not later. In automatic mode the same stimulus must give exactly one follow-up request; in single-shot mode a status change must give none. A reset in mid-packet and control writes of each mode value confirm the withdrawal and reset paths.

// File: rtl/stpkt_pkg.sv
package stpkt_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_ONCE = 2'b01,
    MODE_RSV  = 2'b10,
    MODE_AUTO = 2'b11
  } rpt_mode_e;

  localparam int SEQ_W = 6;

  // Address byte, sequence/low-bits byte, then eight status bits per byte.
  function automatic int pkt_bytes(input int payload_w);
    return 2 + (payload_w - 2 + 7) / 8;
  endfunction

endpackage

// File: rtl/stpkt_ctl.sv
module stpkt_ctl
  import stpkt_pkg::*;
#(
  parameter int PAYLOAD_W = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ctl_we,
  input  logic [7:0]           ctl_data,
  input  logic [PAYLOAD_W-1:0] status_in,
  input  logic                 accept,
  output logic [SEQ_W-1:0]     seq,
  output logic                 want
);

  rpt_mode_e            mode_q;
  logic [PAYLOAD_W-1:0] prev_q;
  rpt_mode_e            wr_mode;
  logic                 arm_w, cancel_w, auto_w;

  assign wr_mode  = rpt_mode_e'(ctl_data[1:0]);
  assign arm_w    = ctl_we && (wr_mode == MODE_ONCE || wr_mode == MODE_AUTO);
  assign cancel_w = ctl_we && !arm_w;
  assign auto_w   = (mode_q == MODE_AUTO) && (status_in != prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_OFF;
      seq    <= '0;
      prev_q <= '0;
      want   <= 1'b0;
    end else begin
      prev_q <= status_in;
      if (ctl_we) begin
        mode_q <= wr_mode;
        seq    <= ctl_data[7:2];
      end
      if (cancel_w)                want <= 1'b0;
      else if (arm_w || auto_w)    want <= 1'b1;
      else if (accept)             want <= 1'b0;
    end
  end

  AST_CANCEL_DROPS: assert property (@(posedge clk) disable iff (rst)
    cancel_w |=> !want);  // R10

endmodule

// File: rtl/stpkt_ser.sv
module stpkt_ser
  import stpkt_pkg::*;
#(
  parameter int         PAYLOAD_W = 9,
  parameter logic [7:0] ADDR_BYTE = 8'h3A
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 go,
  input  logic [PAYLOAD_W-1:0] status_in,
  input  logic [SEQ_W-1:0]     seq_in,
  output logic [7:0]           ad,
  output logic                 busy
);

  localparam int NB    = pkt_bytes(PAYLOAD_W);
  localparam int PAD_W = 2 + 8 * (NB - 2);
  localparam int CW    = $clog2(NB);

  logic [CW-1:0]    cnt;
  logic [PAD_W-1:0] snap;
  logic [SEQ_W-1:0] seq_q;
  logic [7:0]       byte_v [1:NB-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      snap  <= '0;
      seq_q <= '0;
    end else if (go) begin
      cnt   <= CW'(1);
      snap  <= PAD_W'(status_in);
      seq_q <= seq_in;
    end else if (cnt != '0) begin
      cnt <= (cnt == CW'(NB - 1)) ? '0 : cnt + 1'b1;
    end
  end

  assign busy      = (cnt != '0);
  assign byte_v[1] = {seq_q, snap[1:0]};

  for (genvar k = 2; k < NB; k++) begin : g_data
    assign byte_v[k] = snap[2 + 8 * (k - 2) +: 8];
  end

  always_comb begin
    ad = '0;
    if (go) begin
      ad = ADDR_BYTE;
    end else begin
      for (int k = 1; k < NB; k++) begin
        if (cnt == CW'(k)) ad = byte_v[k];
      end
    end
  end

  AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    go |-> !busy);  // R7
  AST_SNAP_HELD: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(snap) && $stable(seq_q)));  // R6
  AST_BURST_END: assert property (@(posedge clk) disable iff (rst)
    (cnt == CW'(NB - 1)) |=> (!busy && ad == 8'h00) || go);  // R5

endmodule

// File: rtl/status_pkt_gen.sv
module status_pkt_gen
  import stpkt_pkg::*;
#(
  parameter int         PAYLOAD_W   = 9,
  parameter logic [7:0] STATUS_ADDR = 8'h3A
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ctl_we,
  input  logic [7:0]           ctl_data,
  input  logic [PAYLOAD_W-1:0] status_in,
  output logic [7:0]           pkt_ad,
  output logic                 pkt_rq,
  input  logic                 pkt_start
);

  logic             want, busy, accept;
  logic [SEQ_W-1:0] seq;

  assign pkt_rq = want && !busy;
  assign accept = pkt_rq && pkt_start;

  stpkt_ctl #(.PAYLOAD_W(PAYLOAD_W)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .ctl_we    (ctl_we),
    .ctl_data  (ctl_data),
    .status_in (status_in),
    .accept    (accept),
    .seq       (seq),
    .want      (want)
  );

  stpkt_ser #(.PAYLOAD_W(PAYLOAD_W), .ADDR_BYTE(STATUS_ADDR)) u_ser (
    .clk       (clk),
    .rst       (rst),
    .go        (accept),
    .status_in (status_in),
    .seq_in    (seq),
    .ad        (pkt_ad),
    .busy      (busy)
  );

  AST_START_ADDR: assert property (@(posedge clk) disable iff (rst)
    (pkt_rq && pkt_start) |-> (pkt_ad == STATUS_ADDR));  // R4
  AST_RQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pkt_rq && !pkt_start && !ctl_we) |=> pkt_rq);  // R3
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pkt_rq && pkt_ad == 8'h00));  // R1

endmodule

// File: tb/test_status_pkt_gen.sv
module test_status_pkt_gen;

  localparam int         W    = 20;
  localparam int         NB   = 2 + (W - 2 + 7) / 8;
  localparam logic [7:0] ADDR = 8'h3A;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ctl_we = 1'b0;
  logic [7:0]   ctl_data = '0;
  logic [W-1:0] status_in = '0;
  logic [7:0]   pkt_ad;
  logic         pkt_rq;
  logic         pkt_start = 1'b0;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #5 clk = ~clk;

  status_pkt_gen #(.PAYLOAD_W(W), .STATUS_ADDR(ADDR)) i_status_pkt_gen (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_data(ctl_data),
    .status_in(status_in), .pkt_ad(pkt_ad), .pkt_rq(pkt_rq), .pkt_start(pkt_start)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int k, input logic [W-1:0] st, input logic [5:0] sq);
    logic [25:0] p;
    p = 26'(st);
    if (k == 0) return ADDR;
    if (k == 1) return {sq, st[1:0]};
    return p[2 + 8 * (k - 2) +: 8];
  endfunction

  task automatic wr(input logic [1:0] mode, input logic [5:0] sq);
    @(negedge clk);
    ctl_we = 1'b1; ctl_data = {sq, mode};
    @(negedge clk);
    ctl_we = 1'b0;
    #1;
  endtask

  // Starts at a negedge with the request high; ends at the idle negedge after the packet.
  task automatic recv(input logic [W-1:0] st, input logic [5:0] sq, input bit bump, input string req);
    pkt_start = 1'b1;
    #1 chk(pkt_ad == ADDR, "R4 addr byte", pkt_ad, ADDR);
    for (int k = 1; k < NB; k++) begin
      @(negedge clk);
      pkt_start = 1'b0;
      if (bump && k == 1) status_in = ~status_in;
      #1 chk(pkt_ad == exp_byte(k, st, sq), req, pkt_ad, exp_byte(k, st, sq));
      chk(!pkt_rq, "R7 no rq mid-packet", pkt_rq, 0);
    end
    @(negedge clk);
    #1 chk(pkt_ad == 8'h00, "R7 bus idle after packet", pkt_ad, 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] st;
    logic [5:0]   sq;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1 chk(pkt_rq == 1'b0, "R1 rq after reset", pkt_rq, 0);
    chk(pkt_ad == 8'h00, "R1 bus after reset", pkt_ad, 0);
    status_in = 20'h5A5A5;
    repeat (3) @(negedge clk);
    #1 chk(pkt_rq == 1'b0, "R1 disabled ignores status", pkt_rq, 0);

    // R4: stray start while idle
    @(negedge clk); pkt_start = 1'b1;
    #1 chk(pkt_ad == 8'h00, "R4 stray start bus", pkt_ad, 0);
    @(negedge clk); pkt_start = 1'b0;
    #1 chk(pkt_ad == 8'h00, "R4 no packet after stray start", pkt_ad, 0);

    // R2/R3: single shot, request held while start withheld
    wr(2'b01, 6'h05);
    chk(pkt_rq == 1'b1, "R3 rq after once write", pkt_rq, 1);
    repeat (4) begin
      @(negedge clk); #1 chk(pkt_rq == 1'b1, "R3 rq held", pkt_rq, 1);
    end
    status_in = 20'hFFFFF;
    @(negedge clk);
    recv(20'hFFFFF, 6'h05, 1'b0, "R5 once packet");
    status_in = 20'h00003;
    repeat (3) @(negedge clk);
    #1 chk(pkt_rq == 1'b0, "R8 once ignores status change", pkt_rq, 0);

    // R10: cancel with 00 and with 10
    wr(2'b01, 6'h11);
    chk(pkt_rq == 1'b1, "R3 rq rearmed", pkt_rq, 1);
    wr(2'b00, 6'h11);
    chk(pkt_rq == 1'b0, "R10 cancel with 00", pkt_rq, 0);
    wr(2'b01, 6'h12);
    wr(2'b10, 6'h12);
    chk(pkt_rq == 1'b0, "R10 cancel with 10", pkt_rq, 0);
    status_in = 20'h12345;
    repeat (2) @(negedge clk);
    #1 chk(pkt_rq == 1'b0, "R2 mode 10 acts as disabled", pkt_rq, 0);

    // R6/R9: auto mode, change during packet
    wr(2'b11, 6'h2A);
    chk(pkt_rq == 1'b1, "R3 auto write requests", pkt_rq, 1);
    st = status_in;
    recv(st, 6'h2A, 1'b1, "R6 snapshot held");
    chk(pkt_rq == 1'b1, "R9 follow-up request", pkt_rq, 1);
    recv(~st, 6'h2A, 1'b0, "R9 follow-up packet");
    repeat (3) begin
      @(negedge clk); #1 chk(pkt_rq == 1'b0, "R9 only one follow-up", pkt_rq, 0);
    end

    // R8/R5: random status in auto mode
    sq = 6'h2A;
    for (int i = 0; i < 30; i++) begin
      if (($urandom % 5) == 0) begin
        sq = 6'($urandom);
        wr(2'b11, sq);
      end else begin
        st = W'($urandom);
        if (st == status_in) st = ~st;
        @(negedge clk); status_in = st;
        @(negedge clk);
        #1 chk(pkt_rq == 1'b1, "R8 auto change requests", pkt_rq, 1);
      end
      st = status_in;
      recv(st, sq, 1'b0, "R5 random packet");
    end

    // R1: reset in mid-packet
    wr(2'b01, 6'h3F);
    pkt_start = 1'b1;
    @(negedge clk); pkt_start = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #1 chk(pkt_ad == 8'h00, "R1 bus after mid reset", pkt_ad, 0);
    chk(pkt_rq == 1'b0, "R1 rq after mid reset", pkt_rq, 0);
    status_in = ~status_in;
    repeat (3) @(negedge clk);
    #1 chk(pkt_rq == 1'b0, "R1 mode off after reset", pkt_rq, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule